// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block gathers interrupt events from up to `NUM_SRC` peripheral sources and hands the processor core a single 3-bit request level. Each source has a pending flag, a mask bit, a software force bit and a programmable priority level from 1 to 7. Level 0 parks a source, so it is never delivered. Each cycle a resolver picks the unmasked pending source with the highest level. Among sources of equal level, the lowest-numbered one wins. The resolver offers that level to the core only when it is strictly above the core's current 3-bit mask.

During an interrupt-acknowledge cycle the block returns the vector number of the winning source, which is `VEC_BASE + n` (64 + n by default). When nothing is being requested it returns the spurious vector 24. The handler retires a request by writing the source number on the clear port. A source whose input or force bit is still active simply becomes pending again. Configuration and status use a flat register port.

The register address is `{space[1:0], index[5:0]}`:
- space `00` is the priority of source `index`, held in data bits [2:0].
- space `01` is a 32-bit mask word, selected by `index` bit 0.
- space `10` is a 32-bit force word, selected the same way.
- space `11` is a read-only pending word, selected the same way.

Within each word, bit b stands for source 32·w + b.

Top module: `prio_intc`

## Requirements
- R1: After reset the request level is 0, every pending, force and priority field reads 0, and every mask bit reads 1.
- R2: A write to space `00` sets the source's 3-bit priority level, and reading it back returns the same value. A source at level 0 is never delivered, even when it is pending and unmasked.
- R3: A source input that is high at a clock edge sets that source's pending flag. The flag stays set after the input drops, and only a clear removes it.
- R4: A source whose mask bit is 1 keeps its pending flag, visible in space `11`, but it takes no part in arbitration.
- R5: A force bit set through space `10` makes its source pending exactly as an asserted input would. The force bit stays set until software writes it back to 0.
- R6: Among eligible sources, the one with the highest level wins. Among sources of equal level, the lowest-numbered one wins.
- R7: The request level equals the winner's level only when that level is strictly greater than the core mask `core_ipl_i`. Otherwise the request level is 0, so a mask of 7 blocks everything.
- R8: While `iack_i` is high, `iack_vec_o` is `VEC_BASE + winner` when a request is present and 24 when none is. While `iack_i` is low, `iack_vec_o` is 0.
- R9: A clear drops the named source's pending flag. If that source's input or force bit is active in the same cycle, the flag stays set.
- R10: `irq_level_o` is registered, so it reflects pending, mask, priority and core mask one clock edge after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_i | input | NUM_SRC | Peripheral interrupt inputs, level-sensitive, active high |
| core_ipl_i | input | 3 | Core's current interrupt mask level |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | SRC_W+2 | Register address {space, index} |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for cfg_addr_i (combinational) |
| clr_en_i | input | 1 | Clear strobe for one pending flag |
| clr_id_i | input | SRC_W | Source number to clear |
| iack_i | input | 1 | Interrupt-acknowledge cycle in progress |
| irq_level_o | output | 3 | Request level offered to the core, 0 means none |
| iack_vec_o | output | 8 | Vector number returned during acknowledge |

## Verification
Two events can land on the same clock edge: a clear of a source, and a fresh assertion of that source by its input or force bit. The bench holds source 9 high and issues a clear of source 9 in the same cycle. It then reads the pending word and expects bit 9 still set, because the set has to win. The bench repeats the test after the input has dropped, and this time it expects the flag to fall.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned LVL_W        = 3;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned SPURIOUS_VEC = 24;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [1:0] {
    SP_PRIO  = 2'b00,
    SP_MASK  = 2'b01,
    SP_FORCE = 2'b10,
    SP_PEND  = 2'b11
  } space_e;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned SRC_W   = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we_i,
  input  logic [SRC_W+1:0]              addr_i,
  input  logic [WORD_W-1:0]             wdata_i,
  input  logic [NUM_SRC-1:0]            pend_i,
  output logic [NUM_SRC-1:0][LVL_W-1:0] prio_o,
  output logic [NUM_SRC-1:0]            mask_o,
  output logic [NUM_SRC-1:0]            force_o,
  output logic [WORD_W-1:0]             rdata_o
);
  localparam int unsigned WORDS = NUM_SRC / WORD_W;
  localparam int unsigned WI_W  = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [NUM_SRC-1:0][LVL_W-1:0] prio_q, prio_d;
  logic [NUM_SRC-1:0]            mask_q, mask_d;
  logic [NUM_SRC-1:0]            force_q, force_d;

  space_e            space;
  logic [SRC_W-1:0]  src_sel;
  logic [WI_W-1:0]   word_sel;

  assign space    = space_e'(addr_i[SRC_W+1:SRC_W]);
  assign src_sel  = addr_i[SRC_W-1:0];
  assign word_sel = addr_i[WI_W-1:0];

  // next-state
  always_comb begin
    prio_d  = prio_q;
    mask_d  = mask_q;
    force_d = force_q;
    if (we_i) begin
      unique case (space)
        SP_PRIO: prio_d[src_sel] = wdata_i[LVL_W-1:0];
        SP_MASK: begin
          for (int w = 0; w < WORDS; w++)
            if (word_sel == WI_W'(w)) mask_d[w*WORD_W +: WORD_W] = wdata_i;
        end
        SP_FORCE: begin
          for (int w = 0; w < WORDS; w++)
            if (word_sel == WI_W'(w)) force_d[w*WORD_W +: WORD_W] = wdata_i;
        end
        default: ; // pending space is read-only
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q  <= '0;
      mask_q  <= '1;
      force_q <= '0;
    end else if (we_i) begin
      prio_q  <= prio_d;
      mask_q  <= mask_d;
      force_q <= force_d;
    end
  end

  // readback
  always_comb begin
    rdata_o = '0;
    unique case (space)
      SP_PRIO: rdata_o = WORD_W'(prio_q[src_sel]);
      SP_MASK: begin
        for (int w = 0; w < WORDS; w++)
          if (word_sel == WI_W'(w)) rdata_o = mask_q[w*WORD_W +: WORD_W];
      end
      SP_FORCE: begin
        for (int w = 0; w < WORDS; w++)
          if (word_sel == WI_W'(w)) rdata_o = force_q[w*WORD_W +: WORD_W];
      end
      default: begin
        for (int w = 0; w < WORDS; w++)
          if (word_sel == WI_W'(w)) rdata_o = pend_i[w*WORD_W +: WORD_W];
      end
    endcase
  end

  assign prio_o  = prio_q;
  assign mask_o  = mask_q;
  assign force_o = force_q;

  AST_FORCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!we_i) |-> $stable(force_q)) else $error("force bits moved without a write"); // R5
endmodule

// File: rtl/intc_pend.sv
module intc_pend #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned SRC_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] force_i,
  input  logic               clr_en_i,
  input  logic [SRC_W-1:0]   clr_id_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] pend_q, pend_d, clr_vec, set_vec;

  always_comb begin
    clr_vec = '0;
    if (clr_en_i) clr_vec[clr_id_i] = 1'b1;
  end

  assign set_vec = src_i | force_i;

  // set wins over clear in the same cycle
  always_comb begin
    pend_d = set_vec | (pend_q & ~clr_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pend_q) & $past(pend_q) & ~$past(clr_vec)) == '0) else $error("pending lost without clear"); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pend_q) & $past(set_vec)) == '0) else $error("active source not pending"); // R9
endmodule

// File: rtl/intc_resolve.sv
module intc_resolve
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned SRC_W   = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0]            pend_i,
  input  logic [NUM_SRC-1:0]            mask_i,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] prio_i,
  input  lvl_t                          core_ipl_i,
  output lvl_t                          lvl_o,
  output logic [SRC_W-1:0]              id_o
);
  logic [NUM_SRC-1:0] cand;
  lvl_t               best_lvl, lvl_d, lvl_q;
  logic [SRC_W-1:0]   best_id, id_q;

  assign cand = pend_i & ~mask_i;

  // strict compare keeps the lowest index on ties; level 0 never wins
  always_comb begin
    best_lvl = '0;
    best_id  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (prio_i[i] > best_lvl)) begin
        best_lvl = prio_i[i];
        best_id  = SRC_W'(i);
      end
    end
    lvl_d = (best_lvl > core_ipl_i) ? best_lvl : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      id_q  <= '0;
    end else begin
      lvl_q <= lvl_d;
      id_q  <= best_id;
    end
  end

  assign lvl_o = lvl_q;
  assign id_o  = id_q;

  AST_ABOVE_IPL: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != '0) |-> (lvl_q > $past(core_ipl_i))) else $error("level not above core mask"); // R7
  AST_NO_CAND_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cand) == '0) |-> (lvl_q == '0)) else $error("request without eligible source"); // R4
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 64,
  parameter int unsigned VEC_BASE = 64,
  parameter int unsigned VEC_W    = 8,
  localparam int unsigned SRC_W   = $clog2(NUM_SRC),
  localparam int unsigned ADDR_W  = SRC_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [2:0]         core_ipl_i,
  input  logic               cfg_we_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [31:0]        cfg_wdata_i,
  output logic [31:0]        cfg_rdata_o,
  input  logic               clr_en_i,
  input  logic [SRC_W-1:0]   clr_id_i,
  input  logic               iack_i,
  output logic [2:0]         irq_level_o,
  output logic [VEC_W-1:0]   iack_vec_o
);
  logic [NUM_SRC-1:0][LVL_W-1:0] prio;
  logic [NUM_SRC-1:0]            mask, frc, pend;
  lvl_t                          lvl;
  logic [SRC_W-1:0]              win_id;

  intc_regs #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .pend_i(pend), .prio_o(prio), .mask_o(mask),
    .force_o(frc), .rdata_o(cfg_rdata_o)
  );

  intc_pend #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .force_i(frc),
    .clr_en_i(clr_en_i), .clr_id_i(clr_id_i), .pend_o(pend)
  );

  intc_resolve #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_res (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask), .prio_i(prio),
    .core_ipl_i(core_ipl_i), .lvl_o(lvl), .id_o(win_id)
  );

  always_comb begin
    if (!iack_i)          iack_vec_o = '0;
    else if (lvl != '0)   iack_vec_o = VEC_W'(VEC_BASE) + VEC_W'(win_id);
    else                  iack_vec_o = VEC_W'(SPURIOUS_VEC);
  end

  assign irq_level_o = lvl;

  AST_IACK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_i && (irq_level_o != '0)) |-> (iack_vec_o >= VEC_W'(VEC_BASE))) else $error("vector below base"); // R8
endmodule

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
  localparam int NS = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [NS-1:0] src;
  logic [2:0]  ipl;
  logic        we;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        clr_en;
  logic [5:0]  clr_id;
  logic        iack;
  logic [2:0]  lvl;
  logic [7:0]  vec;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk; // 50 MHz

  prio_intc u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .core_ipl_i(ipl),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .clr_en_i(clr_en), .clr_id_i(clr_id), .iack_i(iack),
    .irq_level_o(lvl), .iack_vec_o(vec)
  );

  typedef struct packed {
    logic [5:0] ida; logic [2:0] la;
    logic [5:0] idb; logic [2:0] lb;
    logic [2:0] ipl; logic [2:0] el; logic [7:0] ev;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{6'd3,  3'd5, 6'd10, 3'd2, 3'd0, 3'd5, 8'd67},  // R6 higher level first
    '{6'd3,  3'd2, 6'd10, 3'd6, 3'd0, 3'd6, 8'd74},  // R6 higher level second
    '{6'd20, 3'd4, 6'd7,  3'd4, 3'd0, 3'd4, 8'd71},  // R6 tie -> lower id
    '{6'd40, 3'd3, 6'd63, 3'd3, 3'd2, 3'd3, 8'd104}, // R6 tie, R7 above mask
    '{6'd5,  3'd3, 6'd6,  3'd3, 3'd3, 3'd0, 8'd24},  // R7 equal to mask blocked
    '{6'd0,  3'd7, 6'd1,  3'd1, 3'd6, 3'd7, 8'd64},  // R7 level 7 over mask 6
    '{6'd12, 3'd6, 6'd13, 3'd1, 3'd7, 3'd0, 8'd24},  // R7 mask 7 blocks all
    '{6'd63, 3'd1, 6'd62, 3'd0, 3'd0, 3'd1, 8'd127}  // R2 level 0 never wins
  };

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sp, input int idx, input logic [31:0] d);
    we = 1'b1; addr = {sp, idx[5:0]}; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sp, input int idx, output logic [31:0] d);
    addr = {sp, idx[5:0]};
    #1 d = rdata;
  endtask

  task automatic clr(input int id);
    clr_en = 1'b1; clr_id = id[5:0];
    tick();
    clr_en = 1'b0;
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_sim();
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; src = '0; ipl = '0; we = 1'b0; addr = '0; wdata = '0;
    clr_en = 1'b0; clr_id = '0; iack = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 level", 32'(lvl), 0);
    rd(2'b11, 0, r); chk("R1 pend w0", r, 0);
    rd(2'b01, 0, r); chk("R1 mask w0", r, 32'hFFFF_FFFF);
    rd(2'b01, 1, r); chk("R1 mask w1", r, 32'hFFFF_FFFF);
    rd(2'b10, 1, r); chk("R1 force w1", r, 0);
    rd(2'b00, 5, r); chk("R1 prio", r, 0);

    wr(2'b01, 0, 32'h0);
    wr(2'b01, 1, 32'h0);

    // vector table
    foreach (TBL[k]) begin
      wr(2'b00, int'(TBL[k].ida), 32'(TBL[k].la));
      wr(2'b00, int'(TBL[k].idb), 32'(TBL[k].lb));
      ipl = TBL[k].ipl;
      src = '0; src[TBL[k].ida] = 1'b1; src[TBL[k].idb] = 1'b1;
      tick();
      src = '0;
      tick();
      chk($sformatf("R6/R7 level row %0d", k), 32'(lvl), 32'(TBL[k].el));
      iack = 1'b1; #1;
      chk($sformatf("R8 vector row %0d", k), 32'(vec), 32'(TBL[k].ev));
      iack = 1'b0;
      clr(int'(TBL[k].ida));
      clr(int'(TBL[k].idb));
      wr(2'b00, int'(TBL[k].ida), 0);
      wr(2'b00, int'(TBL[k].idb), 0);
      ipl = '0;
    end

    // R2 readback
    wr(2'b00, 33, 32'd6);
    rd(2'b00, 33, r); chk("R2 prio readback", r, 6);
    wr(2'b00, 33, 0);

    // R3 sticky pending, R10 one-clock latency on clear
    wr(2'b00, 9, 32'd4);
    src[9] = 1'b1; tick(); src[9] = 1'b0;
    tick(); tick();
    rd(2'b11, 0, r); chk("R3 pend held", r, 32'h200);
    chk("R3 level", 32'(lvl), 4);
    iack = 1'b1; #1; chk("R8 vector src9", 32'(vec), 73); iack = 1'b0; #1;
    chk("R8 idle vector", 32'(vec), 0);
    clr(9);
    rd(2'b11, 0, r); chk("R3 pend cleared", r, 0);
    chk("R10 level lags clear", 32'(lvl), 4);
    tick();
    chk("R10 level after clear", 32'(lvl), 0);

    // R4 masked stays pending, not delivered
    wr(2'b01, 0, 32'h200);
    src[9] = 1'b1; tick(); src[9] = 1'b0; tick(); tick();
    rd(2'b11, 0, r); chk("R4 masked pending", r, 32'h200);
    chk("R4 masked level", 32'(lvl), 0);
    wr(2'b01, 0, 32'h0);
    tick();
    chk("R4 unmasked level", 32'(lvl), 4);
    // R10 core mask change
    ipl = 3'd4; #1;
    chk("R10 level before mask edge", 32'(lvl), 4);
    tick();
    chk("R7 level blocked by mask 4", 32'(lvl), 0);
    ipl = 3'd0;
    clr(9); tick();

    // R5 force
    wr(2'b10, 0, 32'h200);
    chk("R10 force not yet visible", 32'(lvl), 0);
    tick(); tick();
    chk("R5 forced level", 32'(lvl), 4);
    clr(9); tick();
    rd(2'b11, 0, r); chk("R5 force repends", r, 32'h200);
    rd(2'b10, 0, r); chk("R5 force kept", r, 32'h200);
    wr(2'b10, 0, 32'h0);
    clr(9); tick();
    chk("R5 level after unforce", 32'(lvl), 0);

    // R9 clear and set in the same cycle
    src[9] = 1'b1; tick();
    clr(9);
    rd(2'b11, 0, r); chk("R9 set wins over clear", r, 32'h200);
    src[9] = 1'b0;
    clr(9);
    rd(2'b11, 0, r); chk("R9 clear after drop", r, 0);
    tick();
    chk("R9 level idle", 32'(lvl), 0);

    finish_sim();
  end
endmodule